// File: doc/BRIEF.md
# Two-Level Overcurrent Fault Detector

This block decides when a multi-phase converter must shut down because of excess current. Two protection tiers share one comparison reference. The first tier watches a continuous flag that reports whether the combined average current is above the reference. The second tier watches one flag per phase, each saying whether that phase's current is above the same reference. A strobe marks each switching cycle.

The average tier trips at once. Its flag reaches the shutdown output through logic alone, with no register in the path. The per-phase tier trips only when one phase stays over the limit for a run of consecutive switching cycles. The default run is eight cycles. Each phase is judged on its own. A run on any single phase shuts down the whole converter.

The shutdown request is held in a latch until a synchronous clear input removes it. A status output names every phase that completed a run, and a separate bit records an average-current event.

Top module: `oc_guard`

## Requirements
- R1: After reset is released, `trip_o` is 0, `cause_ch_o` is all zero and `cause_avg_o` is 0.
- R2: While `avg_over_i` is 1, `trip_o` is 1 in the same cycle, with no clock edge and no strobe needed. `cause_avg_o` is still 0 in that first cycle.
- R3: If `avg_over_i` is 1 at a rising clock edge, then from that edge on `trip_o` and `cause_avg_o` stay 1 after `avg_over_i` returns to 0.
- R4: A strobe is a cycle with `tick_i` = 1. When phase k's flag `ch_over_i[k]` is 1 on 8 (RUN_LEN) consecutive strobes, `trip_o` becomes 1 right after the clock edge of the 8th strobe, and bit k of `cause_ch_o` becomes 1 at the same edge. It does not happen after the 7th strobe.
- R5: A strobe with `ch_over_i[k]` = 0 restarts phase k's run. Seven over-limit strobes, then one clean strobe, then seven more over-limit strobes do not trip.
- R6: `ch_over_i` is sampled only on strobes. Its value on cycles with `tick_i` = 0 neither adds to a run nor breaks one, however many such cycles fall between strobes.
- R7: Runs are counted per phase. Over-limit strobes that alternate between two phases never trip, however long the sequence.
- R8: When several phases complete a run at the same strobe, every one of their bits in `cause_ch_o` is set.
- R9: `clr_i` = 1 at a clock edge clears `trip_o` (when `avg_over_i` is 0), `cause_ch_o`, `cause_avg_o` and every run in progress. After a clear, a phase needs a full 8 fresh over-limit strobes to trip.
- R10: Once tripped, the block stays tripped with all inputs idle. Later causes are added to the status bits, and earlier ones are kept, until `clr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the latch, status and run counters |
| tick_i | input | 1 | Switching-cycle strobe, one clock wide |
| avg_over_i | input | 1 | Average current above the reference |
| ch_over_i | input | NUM_CH | Per-phase current above the reference |
| trip_o | output | 1 | Shutdown request |
| cause_ch_o | output | NUM_CH | Phases that completed an over-limit run |
| cause_avg_o | output | 1 | An average-current event was latched |

## Verification
The assertions assume that every flag and the strobe are synchronous to `clk_i` and stable around the rising edge. The bench meets this by driving all inputs on the falling edge only. The check that ties a new status bit to a strobe assumes that a phase bit can only appear when the previous edge carried a strobe with that phase over the limit. The bench never forces status any other way, so this holds. The run-length sweep changes the phase, the run length, the number of idle cycles between strobes and the flag value on those idle cycles. It does this so that sampling outside strobes is exercised in both directions.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;
  parameter int unsigned NUM_CH_DEF  = 4;
  parameter int unsigned RUN_LEN_DEF = 8;

  function automatic int unsigned cnt_w(input int unsigned run_len);
    return (run_len < 2) ? 1 : $clog2(run_len + 1);
  endfunction
endpackage

// File: rtl/oc_run_counter.sv
module oc_run_counter #(
  parameter int unsigned RUN_LEN = oc_guard_pkg::RUN_LEN_DEF,
  localparam int unsigned CW     = oc_guard_pkg::cnt_w(RUN_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic over_i,
  output logic hit_o
);
  logic [CW-1:0] cnt_q;
  logic          at_last;
  logic          at_sat;

  assign at_last = (cnt_q == CW'(RUN_LEN - 1));
  assign at_sat  = (cnt_q == CW'(RUN_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (!over_i)     cnt_q <= '0;
      else if (!at_sat) cnt_q <= cnt_q + 1'b1;
    end
  end

  // run completes on this strobe
  assign hit_o = tick_i & over_i & at_last & ~clr_i;
endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int unsigned NUM_CH = oc_guard_pkg::NUM_CH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              avg_over_i,
  input  logic [NUM_CH-1:0] hit_i,
  output logic              trip_o,
  output logic [NUM_CH-1:0] cause_ch_o,
  output logic              cause_avg_o
);
  logic              trip_q;
  logic [NUM_CH-1:0] cause_ch_q;
  logic              cause_avg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q      <= 1'b0;
      cause_ch_q  <= '0;
      cause_avg_q <= 1'b0;
    end else if (clr_i) begin
      trip_q      <= 1'b0;
      cause_ch_q  <= '0;
      cause_avg_q <= 1'b0;
    end else begin
      trip_q      <= trip_q | avg_over_i | (|hit_i);
      cause_ch_q  <= cause_ch_q | hit_i;
      cause_avg_q <= cause_avg_q | avg_over_i;
    end
  end

  // average tier bypasses the register
  assign trip_o      = trip_q | avg_over_i;
  assign cause_ch_o  = cause_ch_q;
  assign cause_avg_o = cause_avg_q;
endmodule

// File: rtl/oc_guard.sv
module oc_guard #(
  parameter int unsigned NUM_CH  = oc_guard_pkg::NUM_CH_DEF,
  parameter int unsigned RUN_LEN = oc_guard_pkg::RUN_LEN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              avg_over_i,
  input  logic [NUM_CH-1:0] ch_over_i,
  output logic              trip_o,
  output logic [NUM_CH-1:0] cause_ch_o,
  output logic              cause_avg_o
);
  logic [NUM_CH-1:0] hit;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    oc_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .tick_i (tick_i),
      .over_i (ch_over_i[k]),
      .hit_o  (hit[k])
    );
  end

  oc_fault_latch #(.NUM_CH(NUM_CH)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .avg_over_i  (avg_over_i),
    .hit_i       (hit),
    .trip_o      (trip_o),
    .cause_ch_o  (cause_ch_o),
    .cause_avg_o (cause_avg_o)
  );
endmodule

// File: rtl/oc_guard_chk.sv
module oc_guard_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              tick_i,
  input logic              avg_over_i,
  input logic [NUM_CH-1:0] ch_over_i,
  input logic              trip_o,
  input logic [NUM_CH-1:0] cause_ch_o,
  input logic              cause_avg_o
);
  // R2
  avg_instant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_over_i |-> trip_o);

  // R3
  trip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !clr_i) |=> trip_o);

  // R9
  clear_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cause_ch_o == '0) && !cause_avg_o);

  // R10
  cause_implies_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cause_ch_o) || cause_avg_o) |-> trip_o);

  // R6
  cause_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(cause_ch_o & ~$past(cause_ch_o) & ~($past(ch_over_i) & {NUM_CH{$past(tick_i)}}))));

  // R4
  rise_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(trip_o) && !avg_over_i) |-> (|cause_ch_o));
endmodule

bind oc_guard oc_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .tick_i      (tick_i),
  .avg_over_i  (avg_over_i),
  .ch_over_i   (ch_over_i),
  .trip_o      (trip_o),
  .cause_ch_o  (cause_ch_o),
  .cause_avg_o (cause_avg_o)
);

// File: tb/oc_guard_tb_top.sv
`timescale 1ns/1ps
module oc_guard_tb_top;
  localparam int unsigned N   = 4;
  localparam int unsigned RUN = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_i = 1'b0;
  logic         tick_i = 1'b0;
  logic         avg_over_i = 1'b0;
  logic [N-1:0] ch_over_i = '0;
  logic         trip_o;
  logic [N-1:0] cause_ch_o;
  logic         cause_avg_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  oc_guard #(.NUM_CH(N), .RUN_LEN(RUN)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .tick_i      (tick_i),
    .avg_over_i  (avg_over_i),
    .ch_over_i   (ch_over_i),
    .trip_o      (trip_o),
    .cause_ch_o  (cause_ch_o),
    .cause_avg_o (cause_avg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one strobe carrying v, then idle cycles with idle_v on the flags
  task automatic strobe(input logic [N-1:0] v, input int gap, input logic [N-1:0] idle_v);
    @(negedge clk_i);
    tick_i = 1'b1; ch_over_i = v;
    @(negedge clk_i);
    tick_i = 1'b0; ch_over_i = idle_v;
    for (int g = 0; g < gap; g++) @(negedge clk_i);
  endtask

  task automatic do_clr();
    @(negedge clk_i);
    clr_i = 1'b1; ch_over_i = '0;
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 trip", trip_o, 0);
    chk("R1 cause_ch", cause_ch_o, 0);
    chk("R1 cause_avg", cause_avg_o, 0);

    // R4 R5 R6 sweep: phase, run length, idle gap, idle flag value
    for (int k = 0; k < N; k++) begin
      for (int len = 0; len <= RUN + 2; len++) begin
        for (int gap = 0; gap < 3; gap++) begin
          for (int gf = 0; gf < 2; gf++) begin
            logic [N-1:0] one;
            logic [N-1:0] idle;
            one  = N'(1) << k;
            idle = (gf != 0) ? one : '0;
            for (int i = 1; i <= len; i++) begin
              strobe(one, gap, idle);
              chk("R4 R6 run trip", trip_o, (i >= RUN) ? 1 : 0);
              chk("R4 run cause", cause_ch_o, (i >= RUN) ? one : '0);
            end
            strobe('0, gap, idle);
            chk("R5 break", trip_o, (len >= RUN) ? 1 : 0);
            for (int i = 1; i < RUN; i++) strobe(one, gap, idle);
            chk("R5 restart", trip_o, (len >= RUN) ? 1 : 0);
            do_clr();
            chk("R9 clear trip", trip_o, 0);
            chk("R9 clear cause", cause_ch_o, 0);
          end
        end
      end
    end

    // R2 R3 average tier
    @(negedge clk_i);
    avg_over_i = 1'b1;
    #1;
    chk("R2 instant trip", trip_o, 1);
    chk("R2 cause_avg first cycle", cause_avg_o, 0);
    @(negedge clk_i);
    avg_over_i = 1'b0;
    #1;
    chk("R3 trip held", trip_o, 1);
    chk("R3 cause_avg", cause_avg_o, 1);
    repeat (5) @(negedge clk_i);
    chk("R3 still held", trip_o, 1);
    do_clr();
    chk("R9 clear avg", cause_avg_o, 0);
    chk("R9 clear trip avg", trip_o, 0);

    // R7 alternating phases
    for (int i = 0; i < 3 * RUN; i++) strobe((i % 2 == 0) ? N'(1) : N'(2), 1, '0);
    chk("R7 alternate no trip", trip_o, 0);
    chk("R7 alternate cause", cause_ch_o, 0);

    // R8 simultaneous phases
    for (int i = 0; i < RUN; i++) strobe(N'(5), 0, '0);
    chk("R8 multi trip", trip_o, 1);
    chk("R8 multi cause", cause_ch_o, 5);
    do_clr();

    // R10 hold and accumulate
    for (int i = 0; i < RUN; i++) strobe(N'(8), 0, '0);
    repeat (6) @(negedge clk_i);
    chk("R10 idle hold", trip_o, 1);
    chk("R10 cause kept", cause_ch_o, 8);
    avg_over_i = 1'b1;
    @(negedge clk_i);
    avg_over_i = 1'b0;
    chk("R10 avg added", cause_avg_o, 1);
    for (int i = 0; i < RUN; i++) strobe(N'(2), 0, '0);
    chk("R10 cause accumulate", cause_ch_o, 10);
    chk("R10 avg kept", cause_avg_o, 1);
    do_clr();

    // R9 clear drops a partial run
    for (int i = 0; i < 5; i++) strobe(N'(1), 0, '0);
    do_clr();
    for (int i = 0; i < RUN - 1; i++) strobe(N'(1), 0, '0);
    chk("R9 partial run dropped", trip_o, 0);
    strobe(N'(1), 0, '0);
    chk("R9 fresh run trips", trip_o, 1);
    chk("R9 fresh run cause", cause_ch_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule